// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The chain walker follows a singly linked list of command nodes held in a word-organised memory. It forwards the payload words of each node to a downstream consumer. Each node starts with one header word. The header carries a payload length and the link to the next node. The payload words sit directly after the header, at increasing addresses.

A walk begins on a start strobe that carries the first node address. The block then works through the list in this order:

1. It reads a header.
2. It streams that node's payload over a valid/ready port.
3. It moves to the linked node.

The walk ends normally when the current link has its top flag bit set. A guard counts the headers read. It aborts a list that never terminates, which in practice means a cycle in the list.

On completion the block pulses a done signal and reports two things: the last link it reached and the number of nodes visited. The memory side is a simple request/response read port with a single outstanding request.

Top module: `chain_walker`

## Requirements
- R1: A header word is decoded with the payload length in bits 31:24 and the 24-bit next-node link in bits 23:0.
- R2: A link whose bit 23 is set ends the walk. No memory read is issued for it, `err_o` stays low and `last_addr_o` reports that link.
- R3: Links are 24 bits wide. Only byte-address bits 20:2 select a memory word (`mem_addr_o` = link[20:2]), so bits 22:21 and 1:0 alias.
- R4: A node of length 0 forwards no payload word, and the walk continues with its next link.
- R5: Payload words leave in increasing address order. `pay_data_o` holds steady while `pay_valid_o` is high and `pay_ready_i` is low. The next header is requested only after the node's last payload word is accepted.
- R6: When LOOP_LIMIT headers have been read and the current link is not an end link, the walk aborts with `err_o` high and `last_addr_o` = 24'hFFFFFF.
- R7: `busy_o` rises the cycle after an accepted start and falls when `done_o` pulses for exactly one cycle. A start while busy is ignored.
- R8: `node_cnt_o` gives the number of headers read in the current or most recent walk.
- R9: At most one memory read is outstanding. `mem_req_o` is a one-cycle pulse and is never raised while a response is pending or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| start_addr_i | input | 24 | Link of the first node |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | MEM_BYTE_AW-2 | Word address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pay_valid_o | output | 1 | Payload word valid |
| pay_data_o | output | 32 | Payload word |
| pay_ready_i | input | 1 | Consumer accepts the payload word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last walk was aborted by the loop guard |
| last_addr_o | output | 24 | Final link reached, or 24'hFFFFFF on abort |
| node_cnt_o | output | $clog2(LOOP_LIMIT+1) | Headers read in the walk |

## Verification
The assertions assume the memory answers each request with exactly one `mem_rvalid_i` pulse, and never returns one without a pending request. The bench memory model is built that way: it replies one cycle after each request.

The assertions also assume `pay_ready_i` is driven only between clock edges. The bench drives it and `start_i` on the falling edge, and it alternates ready stalls to exercise payload holding. The loop guard is reduced to a small limit so that a self-linked node trips it within a few nodes.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;

    localparam int WORD_W   = 32;
    localparam int LINK_W   = 24;
    localparam int LEN_W    = 8;
    localparam int END_BIT  = 23;
    localparam logic [LINK_W-1:0] ABORT_LINK = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_PAY_SEND
    } walk_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [LINK_W-1:0] next;
    } node_hdr_t;

endpackage

// File: rtl/chain_hdr_decode.sv
module chain_hdr_decode
    import chain_walk_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output node_hdr_t         hdr_o,
    output logic              empty_o
);
    // length occupies the top byte, link the lower 24 bits
    always_comb begin
        hdr_o   = node_hdr_t'(word_i);
        empty_o = (hdr_o.len == '0);
    end
endmodule

// File: rtl/chain_node_guard.sv
module chain_node_guard #(
    parameter int LOOP_LIMIT = 8192,
    localparam int CNT_W     = $clog2(LOOP_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             trip_o
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear_i) begin
            count_d = '0;
        end else if (step_i && !trip_o) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;
    assign trip_o  = (count_q >= CNT_W'(LOOP_LIMIT));
endmodule

// File: rtl/chain_walker.sv
module chain_walker
    import chain_walk_pkg::*;
#(
    parameter int MEM_BYTE_AW = 21,
    parameter int LOOP_LIMIT  = 8192,
    localparam int WORD_AW    = MEM_BYTE_AW - 2,
    localparam int CNT_W      = $clog2(LOOP_LIMIT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LINK_W-1:0]   start_addr_i,
    output logic                mem_req_o,
    output logic [WORD_AW-1:0]  mem_addr_o,
    input  logic                mem_rvalid_i,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic                pay_valid_o,
    output logic [WORD_W-1:0]   pay_data_o,
    input  logic                pay_ready_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [LINK_W-1:0]   last_addr_o,
    output logic [CNT_W-1:0]    node_cnt_o
);

    typedef struct packed {
        walk_state_e         state;
        logic [LINK_W-1:0]   link;
        logic [LINK_W-1:0]   next;
        logic [WORD_AW-1:0]  ptr;
        logic [LEN_W-1:0]    remain;
        logic [WORD_W-1:0]   data;
        logic                busy;
        logic                done;
        logic                err;
        logic [LINK_W-1:0]   last;
    } walk_t;

    walk_t      s_d, s_q;
    node_hdr_t  hdr;
    logic       hdr_empty;
    logic       guard_clr, guard_step, guard_trip;
    logic       req_d;

    chain_hdr_decode u_hdr (
        .word_i  (mem_rdata_i),
        .hdr_o   (hdr),
        .empty_o (hdr_empty)
    );

    chain_node_guard #(.LOOP_LIMIT(LOOP_LIMIT)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (guard_clr),
        .step_i  (guard_step),
        .count_o (node_cnt_o),
        .trip_o  (guard_trip)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        guard_clr  = 1'b0;
        guard_step = 1'b0;
        req_d      = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.link  = start_addr_i;
                    s_d.busy  = 1'b1;
                    s_d.err   = 1'b0;
                    guard_clr = 1'b1;
                    s_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (s_q.link[END_BIT]) begin
                    s_d.last  = s_q.link;
                    s_d.busy  = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end else if (guard_trip) begin
                    s_d.last  = ABORT_LINK;
                    s_d.err   = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.ptr   = s_q.link[MEM_BYTE_AW-1:2];
                    s_d.state = ST_HDR_REQ;
                end
            end
            ST_HDR_REQ: begin
                req_d     = 1'b1;
                s_d.state = ST_HDR_WAIT;
            end
            ST_HDR_WAIT: begin
                if (mem_rvalid_i) begin
                    guard_step = 1'b1;
                    s_d.next   = hdr.next;
                    s_d.remain = hdr.len;
                    s_d.ptr    = s_q.ptr + 1'b1;
                    if (hdr_empty) begin
                        s_d.link  = hdr.next;
                        s_d.state = ST_CHECK;
                    end else begin
                        s_d.state = ST_PAY_REQ;
                    end
                end
            end
            ST_PAY_REQ: begin
                req_d     = 1'b1;
                s_d.state = ST_PAY_WAIT;
            end
            ST_PAY_WAIT: begin
                if (mem_rvalid_i) begin
                    s_d.data  = mem_rdata_i;
                    s_d.state = ST_PAY_SEND;
                end
            end
            ST_PAY_SEND: begin
                if (pay_ready_i) begin
                    s_d.remain = s_q.remain - 1'b1;
                    s_d.ptr    = s_q.ptr + 1'b1;
                    if (s_q.remain == LEN_W'(1)) begin
                        s_d.link  = s_q.next;
                        s_d.state = ST_CHECK;
                    end else begin
                        s_d.state = ST_PAY_REQ;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_o   = req_d;
    assign mem_addr_o  = s_q.ptr;
    assign pay_valid_o = (s_q.state == ST_PAY_SEND);
    assign pay_data_o  = s_q.data;
    assign busy_o      = s_q.busy;
    assign done_o      = s_q.done;
    assign err_o       = s_q.err;
    assign last_addr_o = s_q.last;

endmodule

// File: rtl/chain_walker_sva.sv
module chain_walker_sva
    import chain_walk_pkg::*;
#(
    parameter int LOOP_LIMIT = 8192,
    localparam int CNT_W     = $clog2(LOOP_LIMIT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_rvalid_i,
    input logic              pay_valid_o,
    input logic [WORD_W-1:0] pay_data_o,
    input logic              pay_ready_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [LINK_W-1:0] last_addr_o,
    input logic [CNT_W-1:0]  node_cnt_o
);
    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pending_q <= 1'b0;
        else if (mem_req_o)    pending_q <= 1'b1;
        else if (mem_rvalid_i) pending_q <= 1'b0;
    end

    AST_PAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o && !pay_ready_i |=> pay_valid_o && $stable(pay_data_o)); // R5
    AST_NO_REQ_DURING_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o |-> !mem_req_o); // R5
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !pending_q); // R9
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !pay_valid_o); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !busy_o && $past(busy_o)); // R7
    AST_ABORT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> last_addr_o == ABORT_LINK); // R6
    AST_END_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !err_o |-> last_addr_o[END_BIT]); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        node_cnt_o <= CNT_W'(LOOP_LIMIT)); // R6
endmodule

bind chain_walker chain_walker_sva #(.LOOP_LIMIT(LOOP_LIMIT)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_o    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .pay_valid_o  (pay_valid_o),
    .pay_data_o   (pay_data_o),
    .pay_ready_i  (pay_ready_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .last_addr_o  (last_addr_o),
    .node_cnt_o   (node_cnt_o)
);

// File: tb/tb_chain_walker.sv
module tb_chain_walker;
    localparam int AW    = 21;
    localparam int LIMIT = 5;
    localparam int WAW   = AW - 2;
    localparam int CW    = $clog2(LIMIT + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [23:0]     start_addr = '0;
    logic            mem_req;
    logic [WAW-1:0]  mem_addr;
    logic            mem_rvalid = 1'b0;
    logic [31:0]     mem_rdata = '0;
    logic            pay_valid;
    logic [31:0]     pay_data;
    logic            pay_ready = 1'b0;
    logic            busy, done, err;
    logic [23:0]     last_addr;
    logic [CW-1:0]   node_cnt;

    always #5 clk = ~clk;

    chain_walker #(.MEM_BYTE_AW(AW), .LOOP_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .pay_valid_o(pay_valid), .pay_data_o(pay_data), .pay_ready_i(pay_ready),
        .busy_o(busy), .done_o(done), .err_o(err),
        .last_addr_o(last_addr), .node_cnt_o(node_cnt)
    );

    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] rd(input logic [WAW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= rd(mem_addr);
    end

    // negedge monitor: drives ready and records accepted words and done
    int          total = 0, bad = 0;
    logic [31:0] got [$];
    int          req_cnt = 0, done_cnt = 0, done_width = 0;
    bit          stall_mode = 0;
    int          phase = 0;
    logic        d_err;
    logic [23:0] d_last;
    int          d_nodes;
    bit          d_busy;

    always @(negedge clk) begin
        phase++;
        pay_ready = stall_mode ? (phase % 3 == 0) : 1'b1;
        if (pay_valid && pay_ready) got.push_back(pay_data);
        if (mem_req) req_cnt++;
        if (done) begin
            done_cnt++;
            d_err   = err;
            d_last  = last_addr;
            d_nodes = int'(node_cnt);
            d_busy  = busy;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_walk(input logic [23:0] a, input bit restart_mid);
        got.delete();
        req_cnt = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1; start_addr = a;
        @(negedge clk); start = 1'b0;
        if (restart_mid) begin
            repeat (3) @(negedge clk);
            start = 1'b1; start_addr = 24'h800000;
            @(negedge clk); start = 1'b0;
        end
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_words(input logic [31:0] exp [$], input string tag);
        chk(got.size() == exp.size(), tag, got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk(got[i] == exp[i], tag, got[i], exp[i]);
    endtask

    function automatic void put(input int byte_addr, input logic [31:0] w);
        mem[(byte_addr & 32'h1FFFFF) >> 2] = w;
    endfunction

    task automatic t_reset;
        chk(!busy && !done && !err, "R7 reset flags", {busy, done, err}, 0);
        chk(!pay_valid && !mem_req, "R9 reset quiet", {pay_valid, mem_req}, 0);
    endtask

    task automatic t_single;
        mem.delete();
        put('h100, {8'd3, 24'h800000});
        put('h104, 32'h11); put('h108, 32'h22); put('h10C, 32'h33);
        run_walk(24'h000100, 0);
        expect_words('{32'h11, 32'h22, 32'h33}, "R1 single node payload");
        chk(d_nodes == 1, "R8 node count", d_nodes, 1);
        chk(d_last == 24'h800000 && !d_err, "R2 end link", d_last, 24'h800000);
        chk(done_cnt == 1 && !d_busy, "R7 done one cycle", done_cnt, 1);
    endtask

    task automatic t_chain_stall;
        mem.delete();
        put('h200, {8'd2, 24'h000340});
        put('h204, 32'hA1); put('h208, 32'hA2);
        put('h340, {8'd0, 24'h000480});
        put('h344, 32'hDEAD);
        put('h480, {8'd1, 24'h8ABCDE});
        put('h484, 32'hC1);
        stall_mode = 1;
        run_walk(24'h000200, 0);
        stall_mode = 0;
        expect_words('{32'hA1, 32'hA2, 32'hC1}, "R4 R5 chain with stalls");
        chk(d_nodes == 3, "R8 three nodes", d_nodes, 3);
        chk(req_cnt == 6, "R5 reads per chain", req_cnt, 6);
        chk(d_last == 24'h8ABCDE, "R2 custom end link", d_last, 24'h8ABCDE);
    endtask

    task automatic t_alias;
        mem.delete();
        put('h600, {8'd1, 24'h900000});
        put('h604, 32'h5A5A);
        run_walk(24'h600602, 0);
        expect_words('{32'h5A5A}, "R3 aliased address");
        chk(d_last == 24'h900000 && !d_err, "R3 aliased end", d_last, 24'h900000);
    endtask

    task automatic t_end_start;
        mem.delete();
        run_walk(24'h800010, 0);
        chk(req_cnt == 0, "R2 no read on end link", req_cnt, 0);
        chk(d_nodes == 0 && got.size() == 0, "R8 zero nodes", d_nodes, 0);
        chk(d_last == 24'h800010, "R2 start end link", d_last, 24'h800010);
    endtask

    task automatic t_loop;
        mem.delete();
        put('h700, {8'd1, 24'h000700});
        put('h704, 32'h77);
        run_walk(24'h000700, 0);
        chk(d_err == 1'b1, "R6 abort flag", d_err, 1);
        chk(d_last == 24'hFFFFFF, "R6 abort link", d_last, 24'hFFFFFF);
        chk(d_nodes == LIMIT, "R6 node limit", d_nodes, LIMIT);
        chk(got.size() == LIMIT, "R6 words before abort", got.size(), LIMIT);
    endtask

    task automatic t_start_busy;
        mem.delete();
        put('h100, {8'd3, 24'h800000});
        put('h104, 32'h11); put('h108, 32'h22); put('h10C, 32'h33);
        run_walk(24'h000100, 1);
        expect_words('{32'h11, 32'h22, 32'h33}, "R7 start while busy ignored");
        chk(done_cnt == 1 && d_last == 24'h800000, "R7 single completion", d_last, 24'h800000);
        chk(!d_err, "R6 err cleared on new walk", d_err, 0);
    endtask

    bit finished = 0;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain_stall();
        t_alias();
        t_end_start();
        t_loop();
        t_start_busy();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule